// File: doc/BRIEF.md
# Nested Priority Interrupt Controller Core

This block keeps per-vector state for a numbered set of exceptions and works out which one the processor should take next. Vectors below 16 are internal exceptions, raised only through the write port. Vectors from 16 upward are external lines, driven by the `irq_in` bus. Every vector has enable, pending and active bits and an 8-bit programmable priority. External vectors also record the last sampled level of their line. Vectors 1, 2 and 3 are reserved. Their priorities are fixed negative values and they are always enabled.

The processor side sees the winning pending vector and its group priority. It also sees the group priority of the most urgent active vector, which is the current execution priority. An acknowledge moves the winner from pending to active. A completion request retires an active vector and returns a three-way nesting status. A query input asks whether one chosen vector is ready to preempt the current execution priority. A small write port programs priorities, enables, pending bits and the priority-group split.

Top module: `npic_core`

## Requirements
- R1: After reset, pend_valid, ack_err, cmp_valid and cur_exc are 0, every programmable priority is 0, the group split field is 0, and exc_prio reads 256.
- R2: Vectors 1, 2 and 3 have fixed priorities -3, -2 and -1 and are always enabled. Priority writes and enable writes to them, and every write to vector 0, are ignored. Pending writes to vectors 1 to 3 take effect.
- R3: A write with wr_en high takes effect at the next clock edge. The wr_sel codes are: 0 sets the priority to wr_data; 1 sets the enable to wr_data[0]; 2 sets the pending bit to wr_data[0]; 3 sets the group split field to wr_data[2:0], and wr_vec is not used for code 3.
- R4: pend_vec is the pending, enabled vector with the lowest signed raw priority, with the lower vector number winning ties. pend_grp is that vector's group priority. A pending vector that is disabled is never selected. pend_valid is 0 when no vector qualifies.
- R5: The group priority of a non-negative priority is that priority with its low (split+1) bits cleared. Negative priorities are used unchanged.
- R6: exc_prio is the lowest group priority among the active vectors, or 256 when none is active. It follows state changes in the same cycle.
- R7: An acknowledge while pend_valid is high clears that vector's pending bit, sets its active bit, and loads cur_exc with its number at the next edge. An acknowledge does not wait for preemption.
- R8: An acknowledge while pend_valid is low changes no state and raises ack_err for exactly the one following cycle.
- R9: A completion request raises cmp_valid for one cycle with cmp_status 2'b11 if the vector was not active, 2'b01 if no vector is active afterwards, and 2'b00 if another vector is still active. The vector's active bit is cleared.
- R10: qry_ready is high when the queried vector is enabled and its group priority is strictly below exc_prio. It is combinational.
- R11: An external line that is high while its recorded level is low sets that vector's pending bit. A line held high does not pend the vector again until it has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target code |
| wr_vec | input | VW | Vector addressed by the write |
| wr_data | input | 8 | Write data |
| irq_in | input | NUM_VEC-16 | External lines; bit i belongs to vector 16+i |
| ack | input | 1 | Acknowledge the selected pending vector |
| cmp_req | input | 1 | Completion request |
| cmp_vec | input | VW | Vector to complete |
| qry_vec | input | VW | Vector to test for readiness |
| pend_valid | output | 1 | A pending enabled vector exists |
| pend_vec | output | VW | Highest-priority pending enabled vector |
| pend_grp | output | PRIO_W+2 | Signed group priority of pend_vec |
| exc_prio | output | PRIO_W+2 | Signed current execution priority |
| cur_exc | output | VW | Most recently acknowledged vector |
| ack_err | output | 1 | Acknowledge arrived with nothing pending |
| cmp_valid | output | 1 | Completion status valid |
| cmp_status | output | 2 | Completion result code |
| qry_ready | output | 1 | Queried vector is ready to preempt |

## Verification
pend_valid, pend_vec, pend_grp, exc_prio and qry_ready are combinational over the registered state. They are due in the cycle that follows the write, line change, acknowledge or completion edge that changed that state. cur_exc, ack_err, cmp_valid and cmp_status are registered at that same edge. ack_err and cmp_valid must fall again one cycle later. The driver applies each stimulus just after a falling edge and queues its expectations just after the next rising edge. The monitor compares the queued items at the following falling edge, so every result is sampled in the cycle it is due.

// File: rtl/npic_pkg.sv
package npic_pkg;
  localparam int PRIO_W    = 8;
  localparam int PW        = PRIO_W + 2;
  localparam int PG_W      = $clog2(PRIO_W);
  localparam int FIRST_EXT = 16;
  localparam int NUM_FIXED = 3;

  typedef logic signed [PW-1:0] sprio_t;

  localparam sprio_t IDLE_PRIO = sprio_t'(1 << PRIO_W);

  typedef enum logic [1:0] {
    WR_PRIO = 2'd0,
    WR_EN   = 2'd1,
    WR_PEND = 2'd2,
    WR_PG   = 2'd3
  } wr_sel_e;

  // raw signed priority of vector v, the reserved ones mapping to -3..-1
  function automatic sprio_t raw_prio(int v, logic [PRIO_W-1:0] p);
    if (v >= 1 && v <= NUM_FIXED) return sprio_t'(v - NUM_FIXED - 1);
    return sprio_t'({2'b00, p});
  endfunction

  function automatic sprio_t group_of(sprio_t raw, logic [PG_W-1:0] pg);
    logic [PRIO_W-1:0] keep;
    if (raw < 0) return raw;
    keep = '1;
    keep = keep << (int'(pg) + 1);
    return sprio_t'({2'b00, raw[PRIO_W-1:0] & keep});
  endfunction
endpackage

// File: rtl/npic_vec_bank.sv
module npic_vec_bank
  import npic_pkg::*;
#(
  parameter int NUM_VEC = 48,
  localparam int VW      = $clog2(NUM_VEC),
  localparam int NUM_EXT = NUM_VEC - FIRST_EXT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [1:0]                      wr_sel,
  input  logic [VW-1:0]                   wr_vec,
  input  logic [PRIO_W-1:0]               wr_data,
  input  logic [NUM_EXT-1:0]              irq_in,
  input  logic                            ack_fire,
  input  logic [VW-1:0]                   ack_vec,
  input  logic                            cmp_fire,
  input  logic [VW-1:0]                   cmp_vec,
  output logic [NUM_VEC-1:0][PRIO_W-1:0]  prio_o,
  output logic [NUM_VEC-1:0]              en_o,
  output logic [NUM_VEC-1:0]              pend_o,
  output logic [NUM_VEC-1:0]              act_o
);
  localparam logic [NUM_VEC-1:0] FIX_EN = NUM_VEC'(4'b1110);

  logic [NUM_VEC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NUM_VEC-1:0]             en_q, en_d, pend_q, pend_d, act_q, act_d;
  logic [NUM_EXT-1:0]             lvl_q, lvl_d;
  logic                           bank_ce;
  logic                           wr_ok, wr_prog;

  assign wr_ok   = wr_en && (int'(wr_vec) > 0) && (int'(wr_vec) < NUM_VEC);
  assign wr_prog = wr_ok && (int'(wr_vec) > NUM_FIXED);
  assign bank_ce = wr_en | ack_fire | cmp_fire | (|(irq_in ^ lvl_q));

  always_comb begin
    prio_d = prio_q;
    en_d   = en_q;
    pend_d = pend_q;
    act_d  = act_q;
    lvl_d  = lvl_q;
    case (wr_sel_e'(wr_sel))
      WR_PRIO: if (wr_prog) prio_d[wr_vec] = wr_data;
      WR_EN:   if (wr_prog) en_d[wr_vec]   = wr_data[0];
      WR_PEND: if (wr_ok)   pend_d[wr_vec] = wr_data[0];
      default: ;
    endcase
    for (int i = 0; i < NUM_EXT; i++) begin
      lvl_d[i] = irq_in[i];
      if (irq_in[i] && !lvl_q[i]) pend_d[FIRST_EXT+i] = 1'b1;
    end
    if (ack_fire) begin
      pend_d[ack_vec] = 1'b0;
      act_d[ack_vec]  = 1'b1;
    end
    if (cmp_fire) act_d[cmp_vec] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= FIX_EN;
      pend_q <= '0;
      act_q  <= '0;
      lvl_q  <= '0;
    end else if (bank_ce) begin
      prio_q <= prio_d;
      en_q   <= en_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      lvl_q  <= lvl_d;
    end
  end

  assign prio_o = prio_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/npic_pend_sel.sv
module npic_pend_sel
  import npic_pkg::*;
#(
  parameter int NUM_VEC = 48,
  localparam int VW = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0][PRIO_W-1:0] prio,
  input  logic [NUM_VEC-1:0]             en,
  input  logic [NUM_VEC-1:0]             pend,
  input  logic [PG_W-1:0]                pg,
  output logic                           sel_valid,
  output logic [VW-1:0]                  sel_vec,
  output sprio_t                         sel_grp
);
  sprio_t best_raw, cand;

  // ascending scan with strict compare: lower number wins a tie
  always_comb begin
    sel_valid = 1'b0;
    sel_vec   = '0;
    best_raw  = IDLE_PRIO;
    cand      = IDLE_PRIO;
    for (int i = 1; i < NUM_VEC; i++) begin
      if (pend[i] && en[i]) begin
        cand = raw_prio(i, prio[i]);
        if (!sel_valid || cand < best_raw) begin
          sel_valid = 1'b1;
          sel_vec   = VW'(i);
          best_raw  = cand;
        end
      end
    end
    sel_grp = sel_valid ? group_of(best_raw, pg) : IDLE_PRIO;
  end
endmodule

// File: rtl/npic_act_track.sv
module npic_act_track
  import npic_pkg::*;
#(
  parameter int NUM_VEC = 48
) (
  input  logic [NUM_VEC-1:0][PRIO_W-1:0] prio,
  input  logic [NUM_VEC-1:0]             act,
  input  logic [PG_W-1:0]                pg,
  output sprio_t                         cur_prio,
  output logic                           multi_act
);
  sprio_t g;
  logic [1:0] seen;

  always_comb begin
    cur_prio = IDLE_PRIO;
    seen     = 2'd0;
    g        = IDLE_PRIO;
    for (int i = 1; i < NUM_VEC; i++) begin
      if (act[i]) begin
        g = group_of(raw_prio(i, prio[i]), pg);
        if (g < cur_prio) cur_prio = g;
        if (seen != 2'd2) seen = seen + 2'd1;
      end
    end
    multi_act = (seen == 2'd2);
  end
endmodule

// File: rtl/npic_core.sv
module npic_core
  import npic_pkg::*;
#(
  parameter int NUM_VEC = 48,
  localparam int VW = $clog2(NUM_VEC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_sel,
  input  logic [VW-1:0]               wr_vec,
  input  logic [PRIO_W-1:0]           wr_data,
  input  logic [NUM_VEC-FIRST_EXT-1:0] irq_in,
  input  logic                        ack,
  input  logic                        cmp_req,
  input  logic [VW-1:0]               cmp_vec,
  input  logic [VW-1:0]               qry_vec,
  output logic                        pend_valid,
  output logic [VW-1:0]               pend_vec,
  output logic [PW-1:0]               pend_grp,
  output logic [PW-1:0]               exc_prio,
  output logic [VW-1:0]               cur_exc,
  output logic                        ack_err,
  output logic                        cmp_valid,
  output logic [1:0]                  cmp_status
  ,output logic                       qry_ready
);
  localparam logic [1:0] ST_NOT_ACT = 2'b11;
  localparam logic [1:0] ST_BASE    = 2'b01;
  localparam logic [1:0] ST_NESTED  = 2'b00;

  logic [NUM_VEC-1:0][PRIO_W-1:0] prio;
  logic [NUM_VEC-1:0]             en, pend, act;
  logic [PG_W-1:0]                pg_q, pg_d;
  logic                           pg_ce;
  logic                           sel_valid, multi_act;
  logic [VW-1:0]                  sel_vec;
  sprio_t                         sel_grp, cur_prio, qry_grp;
  logic                           ack_fire, cmp_in_rng, cmp_hit, cmp_fire;
  logic                           qry_in_rng;

  logic [VW-1:0] cur_exc_q, cur_exc_d;
  logic          ack_err_q, ack_err_d;
  logic          cmp_valid_q, cmp_valid_d;
  logic [1:0]    cmp_status_q, cmp_status_d;
  logic          resp_ce;

  assign ack_fire   = ack && sel_valid;
  assign cmp_in_rng = int'(cmp_vec) < NUM_VEC;
  assign cmp_hit    = cmp_in_rng && act[cmp_vec];
  assign cmp_fire   = cmp_req && cmp_hit;

  npic_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_vec   (wr_vec),
    .wr_data  (wr_data),
    .irq_in   (irq_in),
    .ack_fire (ack_fire),
    .ack_vec  (sel_vec),
    .cmp_fire (cmp_fire),
    .cmp_vec  (cmp_vec),
    .prio_o   (prio),
    .en_o     (en),
    .pend_o   (pend),
    .act_o    (act)
  );

  npic_pend_sel #(.NUM_VEC(NUM_VEC)) u_sel (
    .prio      (prio),
    .en        (en),
    .pend      (pend),
    .pg        (pg_q),
    .sel_valid (sel_valid),
    .sel_vec   (sel_vec),
    .sel_grp   (sel_grp)
  );

  npic_act_track #(.NUM_VEC(NUM_VEC)) u_act (
    .prio      (prio),
    .act       (act),
    .pg        (pg_q),
    .cur_prio  (cur_prio),
    .multi_act (multi_act)
  );

  // group split register
  assign pg_ce = wr_en && (wr_sel_e'(wr_sel) == WR_PG);
  assign pg_d  = wr_data[PG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pg_q <= '0;
    else if (pg_ce) pg_q <= pg_d;
  end

  // response registers
  always_comb begin
    cur_exc_d    = ack_fire ? sel_vec : cur_exc_q;
    ack_err_d    = ack && !sel_valid;
    cmp_valid_d  = cmp_req;
    cmp_status_d = !cmp_hit  ? ST_NOT_ACT :
                   multi_act ? ST_NESTED  : ST_BASE;
  end

  assign resp_ce = ack | cmp_req | ack_err_q | cmp_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_exc_q    <= '0;
      ack_err_q    <= 1'b0;
      cmp_valid_q  <= 1'b0;
      cmp_status_q <= 2'b00;
    end else if (resp_ce) begin
      cur_exc_q    <= cur_exc_d;
      ack_err_q    <= ack_err_d;
      cmp_valid_q  <= cmp_valid_d;
      cmp_status_q <= cmp_req ? cmp_status_d : cmp_status_q;
    end
  end

  // readiness query
  assign qry_in_rng = int'(qry_vec) < NUM_VEC;
  assign qry_grp    = group_of(raw_prio(int'(qry_vec), prio[qry_vec]), pg_q);
  assign qry_ready  = qry_in_rng && en[qry_vec] && (qry_grp < cur_prio);

  assign pend_valid = sel_valid;
  assign pend_vec   = sel_vec;
  assign pend_grp   = sel_grp;
  assign exc_prio   = cur_prio;
  assign cur_exc    = cur_exc_q;
  assign ack_err    = ack_err_q;
  assign cmp_valid  = cmp_valid_q;
  assign cmp_status = cmp_status_q;
endmodule

// File: rtl/npic_core_chk.sv
module npic_core_chk
  import npic_pkg::*;
#(
  parameter int VW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          cmp_req,
  input logic          pend_valid,
  input logic [VW-1:0] pend_vec,
  input logic [VW-1:0] cur_exc,
  input logic          ack_err,
  input logic          cmp_valid,
  input logic [1:0]    cmp_status,
  input logic [PW-1:0] exc_prio,
  input logic          qry_ready
);
  // R8
  ack_err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !pend_valid |=> ack_err);
  // R8
  ack_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> $past(ack) && !$past(pend_valid));
  // R7
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && pend_valid |=> cur_exc == $past(pend_vec));
  // R7
  cur_exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_exc) |-> $past(ack));
  // R9
  cmp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> cmp_status != 2'b10);
  // R9
  cmp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $past(cmp_req));
  // R6
  exc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(exc_prio) <= $signed(IDLE_PRIO));
  // R10
  ready_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qry_ready |-> $signed(exc_prio) > -3);
endmodule

bind npic_core npic_core_chk #(.VW(VW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack        (ack),
  .cmp_req    (cmp_req),
  .pend_valid (pend_valid),
  .pend_vec   (pend_vec),
  .cur_exc    (cur_exc),
  .ack_err    (ack_err),
  .cmp_valid  (cmp_valid),
  .cmp_status (cmp_status),
  .exc_prio   (exc_prio),
  .qry_ready  (qry_ready)
);

// File: tb/npic_core_tb.sv
`timescale 1ns/1ps
module npic_core_tb;
  localparam int NUM_VEC = 48;
  localparam int VW = $clog2(NUM_VEC);
  localparam int NEXT = NUM_VEC - 16;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [1:0] wr_sel;
  logic [VW-1:0] wr_vec;
  logic [7:0] wr_data;
  logic [NEXT-1:0] irq_in;
  logic ack, cmp_req;
  logic [VW-1:0] cmp_vec, qry_vec;
  logic pend_valid, ack_err, cmp_valid, qry_ready;
  logic [VW-1:0] pend_vec, cur_exc;
  logic [9:0] pend_grp, exc_prio;
  logic [1:0] cmp_status;

  always #2.5 clk = ~clk;

  npic_core #(.NUM_VEC(NUM_VEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_vec(wr_vec),
    .wr_data(wr_data), .irq_in(irq_in), .ack(ack), .cmp_req(cmp_req),
    .cmp_vec(cmp_vec), .qry_vec(qry_vec), .pend_valid(pend_valid),
    .pend_vec(pend_vec), .pend_grp(pend_grp), .exc_prio(exc_prio),
    .cur_exc(cur_exc), .ack_err(ack_err), .cmp_valid(cmp_valid),
    .cmp_status(cmp_status), .qry_ready(qry_ready)
  );

  typedef struct { string req; string what; int val; } item_t;
  item_t scb[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic ex(string req, string what, int val);
    item_t it;
    it.req = req; it.what = what; it.val = val;
    scb.push_back(it);
  endtask

  // monitor: compares every queued item at the falling edge
  always @(negedge clk) begin
    while (scb.size() > 0) begin
      item_t it;
      int a;
      it = scb.pop_front();
      case (it.what)
        "pv":   a = int'(pend_valid);
        "pvec": a = int'(pend_vec);
        "pgrp": a = int'($signed(pend_grp));
        "exc":  a = int'($signed(exc_prio));
        "cur":  a = int'(cur_exc);
        "aerr": a = int'(ack_err);
        "cv":   a = int'(cmp_valid);
        "cs":   a = int'(cmp_status);
        "rdy":  a = int'(qry_ready);
        default: a = -999;
      endcase
      n_chk++;
      if (a != it.val) begin
        n_fail++;
        $display("FAIL %s %s actual=%0d expected=%0d", it.req, it.what, a, it.val);
      end
    end
  end

  task automatic wr(int sel, int vec, int data);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = 2'(sel); wr_vec = VW'(vec); wr_data = 8'(data);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); #1; ack = 1'b1;
    @(posedge clk); #1; ack = 1'b0;
  endtask

  task automatic do_cmp(int v);
    @(negedge clk); #1; cmp_req = 1'b1; cmp_vec = VW'(v);
    @(posedge clk); #1; cmp_req = 1'b0;
  endtask

  task automatic set_line(int idx, bit v);
    @(negedge clk); #1; irq_in[idx] = v;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_vec = '0; wr_data = '0;
    irq_in = '0; ack = 1'b0; cmp_req = 1'b0; cmp_vec = '0; qry_vec = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle();
    // R1 reset state
    ex("R1", "pv", 0); ex("R1", "exc", 256); ex("R1", "cur", 0);
    ex("R1", "aerr", 0); ex("R1", "cv", 0);
    // R8 acknowledge with nothing pending
    do_ack();
    ex("R8", "aerr", 1); ex("R8", "pv", 0); ex("R8", "cur", 0);
    idle();
    ex("R8", "aerr", 0);
    // R3 / R4 / R5 basic programming and selection, split = 3
    wr(3, 0, 3);
    wr(0, 20, 8'h4C); wr(1, 20, 1); wr(2, 20, 1);
    ex("R4", "pv", 1); ex("R4", "pvec", 20); ex("R5", "pgrp", 8'h40);
    wr(0, 18, 8'h4C); wr(1, 18, 1); wr(2, 18, 1);
    ex("R4", "pvec", 18);
    wr(0, 19, 8'h10); wr(2, 19, 1);
    ex("R4", "pvec", 18);
    // R2 reserved vector
    wr(0, 2, 0); wr(2, 2, 1);
    ex("R2", "pvec", 2); ex("R2", "pgrp", -2);
    wr(1, 2, 0);
    ex("R2", "pvec", 2);
    // R7 acknowledge
    do_ack();
    qry_vec = VW'(18);
    ex("R7", "cur", 2); ex("R6", "exc", -2); ex("R7", "pvec", 18);
    ex("R10", "rdy", 0);
    // R9 completion back to base
    do_cmp(2);
    ex("R9", "cv", 1); ex("R9", "cs", 1); ex("R6", "exc", 256);
    ex("R10", "rdy", 1);
    do_cmp(5);
    ex("R9", "cv", 1); ex("R9", "cs", 3); ex("R9", "exc", 256);
    idle();
    ex("R9", "cv", 0);
    // R7 nested acknowledges
    do_ack();
    qry_vec = VW'(20);
    ex("R7", "cur", 18); ex("R6", "exc", 8'h40); ex("R10", "rdy", 0);
    do_ack();
    ex("R7", "cur", 20); ex("R6", "exc", 8'h40); ex("R4", "pv", 0);
    do_cmp(20);
    ex("R9", "cs", 0);
    do_cmp(18);
    ex("R9", "cs", 1); ex("R6", "exc", 256);
    // R5 split changes
    wr(2, 20, 1); wr(3, 0, 7);
    ex("R5", "pvec", 20); ex("R5", "pgrp", 0);
    wr(3, 0, 2);
    ex("R5", "pgrp", 8'h48);
    wr(2, 20, 0);
    ex("R3", "pv", 0);
    // R11 external line on vector 24
    wr(0, 24, 8'h10); wr(1, 24, 1);
    set_line(8, 1'b1);
    ex("R11", "pv", 1); ex("R11", "pvec", 24); ex("R11", "pgrp", 8'h10);
    do_ack();
    ex("R11", "cur", 24); ex("R6", "exc", 8'h10); ex("R11", "pv", 0);
    idle();
    ex("R11", "pv", 0);
    set_line(8, 1'b0);
    ex("R11", "pv", 0);
    set_line(8, 1'b1);
    ex("R11", "pv", 1); ex("R11", "pvec", 24);
    do_cmp(24);
    qry_vec = VW'(24);
    ex("R9", "cs", 1); ex("R6", "exc", 256); ex("R10", "rdy", 1);
    idle();
    idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule